// File: doc/BRIEF.md
# Reference clock loss detector

This block watches a set of redundant reference clocks, two by default, and gives each one its own loss-of-reference flag. Each reference is treated as an asynchronous signal. A toggle flop clocked by the reference records its rising edges. The toggle is carried into the feedback clock domain and compared against a window of feedback cycles. If an input holds one level for a whole window, with no rising edge, its flag goes high. The flag drops again as soon as activity is seen.

The references and the feedback clock nominally run at the same rate. The window length `WINDOW` counts feedback cycles and defaults to 2, which absorbs the latency of the synchronizer. The flags report live health: they set on failure and clear on recovery, with nothing latched. An active-low asynchronous reset clears the toggle history and both flags. No flag can rise until one full window of feedback edges has passed after the reset is released.

Top module: `refloss_monitor`

## Requirements
- R1: While `rst_n` is low, every bit of `lor` is 0, whether or not the references toggle.
- R2: After `rst_n` is released with every reference idle, `lor` stays 0 through the first `WINDOW-1` rising edges of `fb_clk`. Every bit is 1 right after edge number `WINDOW`.
- R3: A reference that has a rising edge in every `fb_clk` period keeps its `lor` bit at 0.
- R4: A reference held low keeps its `lor` bit at 1 from no later than `WINDOW+5` `fb_clk` cycles after it stops.
- R5: A reference held high keeps its `lor` bit at 1 from no later than `WINDOW+5` `fb_clk` cycles after it stops.
- R6: Bit i of `lor` depends only on `ref_clk[i]`. A failing reference never sets or clears the flag of another reference.
- R7: Once a failed reference toggles again, its `lor` bit returns to 0 within 5 `fb_clk` cycles of its first new rising edge.
- R8: A `lor` bit stays 1 for as long as its reference stays stuck.
- R9: When all references fail together, every `lor` bit is 1. When all of them recover, every bit returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fb_clk | input | 1 | Feedback clock; the monitor domain and the timing window |
| rst_n | input | 1 | Active-low asynchronous reset for all state |
| ref_clk | input | NUM_REFS | Asynchronous reference clocks being watched, bit i is reference i |
| lor | output | NUM_REFS | Loss-of-reference flags, bit i high while reference i is stuck |

## Verification
The assertions assume that a healthy reference gives at least one rising edge in every `WINDOW` feedback cycles. They also assume that the edges of a reference never fall so close to feedback edges that the synchronized toggle skips a window. The stimulus drives each reference at the feedback period with a fixed phase offset that keeps its edges well away from feedback edges. A reference is stopped only by holding it at a steady level. Reset is released away from any clock edge, so the window count after reset is exact.

// File: rtl/refloss_pkg.sv
package refloss_pkg;

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_state_t;

endpackage

// File: rtl/refloss_toggle.sv
module refloss_toggle (
    input  logic ref_clk,
    input  logic rst_n,
    output logic tog
);
    logic tog_d;
    logic tog_q;

    always_comb begin
        tog_d = ~tog_q;
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= tog_d;
    end

    assign tog = tog_q;
endmodule

// File: rtl/refloss_sync.sv
module refloss_sync
    import refloss_pkg::*;
(
    input  logic fb_clk,
    input  logic rst_n,
    input  logic tog_async,
    output logic chg
);
    sync_state_t st_d;
    sync_state_t st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = tog_async;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge fb_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign chg = st_q.s2 ^ st_q.prev;
endmodule

// File: rtl/refloss_window.sv
module refloss_window #(
    parameter int WINDOW = 2
) (
    input  logic fb_clk,
    input  logic rst_n,
    input  logic chg,
    output logic flag
);
    localparam int CNT_W = $clog2(WINDOW + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WINDOW);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } win_state_t;

    win_state_t st_d;
    win_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (chg) begin
            st_d.cnt  = '0;
            st_d.flag = 1'b0;
        end else begin
            if (st_q.cnt != LIMIT) st_d.cnt = st_q.cnt + 1'b1;
            st_d.flag = (st_d.cnt == LIMIT);
        end
    end

    always_ff @(posedge fb_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
endmodule

// File: rtl/refloss_monitor.sv
module refloss_monitor #(
    parameter int NUM_REFS = 2,
    parameter int WINDOW   = 2
) (
    input  logic                fb_clk,
    input  logic                rst_n,
    input  logic [NUM_REFS-1:0] ref_clk,
    output logic [NUM_REFS-1:0] lor
);
    logic [NUM_REFS-1:0] tog;
    logic [NUM_REFS-1:0] chg;

    for (genvar i = 0; i < NUM_REFS; i++) begin : g_ref
        refloss_toggle u_tog (
            .ref_clk (ref_clk[i]),
            .rst_n   (rst_n),
            .tog     (tog[i])
        );
        refloss_sync u_sync (
            .fb_clk    (fb_clk),
            .rst_n     (rst_n),
            .tog_async (tog[i]),
            .chg       (chg[i])
        );
        refloss_window #(.WINDOW(WINDOW)) u_win (
            .fb_clk (fb_clk),
            .rst_n  (rst_n),
            .chg    (chg[i]),
            .flag   (lor[i])
        );
    end
endmodule

// File: rtl/refloss_monitor_chk.sv
module refloss_monitor_chk #(
    parameter int NUM_REFS = 2,
    parameter int WINDOW   = 2
) (
    input logic                fb_clk,
    input logic                rst_n,
    input logic [NUM_REFS-1:0] chg,
    input logic [NUM_REFS-1:0] lor
);
    localparam int AGE_W = $clog2(WINDOW + 1);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WINDOW);

    logic [AGE_W-1:0] age_q;

    always_ff @(posedge fb_clk or negedge rst_n) begin
        if (!rst_n)              age_q <= '0;
        else if (age_q != AGE_MAX) age_q <= age_q + 1'b1;
    end

    for (genvar i = 0; i < NUM_REFS; i++) begin : g_chk
        // R2: no flag before one full window has passed since reset
        a_r2_no_early_flag: assert property (@(posedge fb_clk) disable iff (!rst_n)
            lor[i] |-> (age_q == AGE_MAX));
        // R4: a flag rises only after a cycle with no activity
        a_r4_rise_when_quiet: assert property (@(posedge fb_clk) disable iff (!rst_n)
            $rose(lor[i]) |-> !$past(chg[i]));
        // R7: seen activity clears the flag at the next edge
        a_r7_clear_on_activity: assert property (@(posedge fb_clk) disable iff (!rst_n)
            chg[i] |=> !lor[i]);
        // R8: a flag holds while no activity arrives
        a_r8_hold_while_stuck: assert property (@(posedge fb_clk) disable iff (!rst_n)
            (lor[i] && !chg[i]) |=> lor[i]);
    end
endmodule

bind refloss_monitor refloss_monitor_chk #(
    .NUM_REFS (NUM_REFS),
    .WINDOW   (WINDOW)
) u_chk (
    .fb_clk (fb_clk),
    .rst_n  (rst_n),
    .chg    (chg),
    .lor    (lor)
);

// File: tb/refloss_monitor_tb.sv
`timescale 1ns/1ps
module refloss_monitor_tb;
    localparam int N   = 2;
    localparam int WIN = 2;

    logic         fb_clk = 1'b0;
    logic         rst_n  = 1'b0;
    logic [N-1:0] ref_clk = '0;
    logic [N-1:0] run  = '0;
    logic [N-1:0] hold = '0;
    logic [N-1:0] lor;

    int total = 0;
    int bad   = 0;

    refloss_monitor #(.NUM_REFS(N), .WINDOW(WIN)) u_dut (
        .fb_clk  (fb_clk),
        .rst_n   (rst_n),
        .ref_clk (ref_clk),
        .lor     (lor)
    );

    always #2 fb_clk = ~fb_clk;

    initial begin
        #0.7;
        forever begin
            #2;
            ref_clk[0] = run[0] ? ~ref_clk[0] : hold[0];
        end
    end

    initial begin
        #1.6;
        forever begin
            #2;
            ref_clk[1] = run[1] ? ~ref_clk[1] : hold[1];
        end
    end

    task automatic check(input logic [N-1:0] act, input logic [N-1:0] exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: lor actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge fb_clk);
        #1;
    endtask

    task automatic t_reset;
        run  = '0;
        hold = '0;
        rst_n = 1'b0;
        step(3);
        check(lor, 2'b00, "R1 idle refs in reset");
        run = '1;
        step(3);
        check(lor, 2'b00, "R1 running refs in reset");
        run = '0;
        step(3);
        @(negedge fb_clk);
        rst_n = 1'b1;
        step(WIN - 1);
        check(lor, 2'b00, "R2 before window end");
        step(1);
        check(lor, 2'b11, "R2 at window end");
    endtask

    task automatic t_running;
        logic [N-1:0] seen;
        run = '1;
        step(6);
        check(lor, 2'b00, "R7 startup clears");
        seen = '0;
        for (int k = 0; k < 40; k++) begin
            step(1);
            seen = seen | lor;
        end
        check(seen, 2'b00, "R3 no flag while toggling");
    endtask

    task automatic t_stuck_low;
        logic [N-1:0] acc;
        run[0]  = 1'b0;
        hold[0] = 1'b0;
        step(WIN + 5);
        check(lor, 2'b01, "R4 ref0 low flags, R6 ref1 clear");
        acc = '1;
        for (int k = 0; k < 30; k++) begin
            step(1);
            acc = acc & lor;
        end
        check(acc[0], 1'b1, "R8 ref0 flag holds");
        run[0] = 1'b1;
        step(5);
        check(lor, 2'b00, "R7 ref0 recovers");
    endtask

    task automatic t_stuck_high;
        run[1]  = 1'b0;
        hold[1] = 1'b1;
        step(WIN + 5);
        check(lor, 2'b10, "R5 ref1 high flags, R6 ref0 clear");
        step(25);
        check(lor, 2'b10, "R8 ref1 flag holds");
        run[1] = 1'b1;
        step(5);
        check(lor, 2'b00, "R7 ref1 recovers");
    endtask

    task automatic t_both;
        run  = '0;
        hold = 2'b01;
        step(WIN + 5);
        check(lor, 2'b11, "R9 both fail");
        run = '1;
        step(5);
        check(lor, 2'b00, "R9 both recover");
        step(10);
        check(lor, 2'b00, "R3 steady after recovery");
    endtask

    initial begin
        t_reset();
        t_running();
        t_stuck_low();
        t_stuck_high();
        t_both();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule